// File: doc/BRIEF.md
# CPU Load-Level Clock Selection Controller

This block decides which clock source and which divider code drive the CPU clock path. When dynamic scaling is on, the choice comes from one of four per-level configurations, indexed by the current 2-bit load level. Level 0 is the fastest and level 3 the slowest. When dynamic scaling is off, the choice comes from a static selection register instead. Software programs everything through a simple write port: the mode bit, the requested load level, the two packed configuration words, the static selection and a command that sets one source for every level.

A transition sequencer sits between the level request and the level in use. A request for level 0 made while the block is at level 2 or 3 is not applied directly. The block first moves to level 1 and raises `busy`. It holds there for a programmable number of settling cycles, which gives the supply time to reach the higher voltage, and only then moves to level 0. A request that arrives during this wait is kept. The most recent one is applied one cycle after the wait ends.

Top module: `cpu_dvfs_clkctl`

## Requirements
- R1: After reset the load level is 0, `busy` is low and dynamic scaling is off. The outputs show the static selection, which resets to source 0, divider code 0 and alternate select 0.
- R2: With dynamic scaling off, the outputs come from the static register (address 4): source in bits [1:0], alternate select in bit 3, divider code in bits [6:4]. A stored divider code of 7 is invalid and is output as 0.
- R3: Bit 31 of the mode register (address 0) enables dynamic scaling. All other bits of that register have no effect.
- R4: Address 2 holds levels 0 and 1, and address 3 holds levels 2 and 3. The even level uses bits [31:16] and the odd level uses bits [15:0]. Within a 16-bit half, the divider code is at bits [15:13], the alternate select at bit 11 and the source at bits [10:9]. With dynamic scaling on, the outputs show the fields of the current level.
- R5: A level request (address 1, bits [1:0]) is applied at the next clock edge when the block is idle, except for a move from level 2 or 3 to level 0.
- R6: A request for level 0 made at level 2 or 3 sets level 1 with `busy` high for SETTLE_CYC cycles. After that, level 0 is set and `busy` falls.
- R7: A level request made while `busy` is high is held, and a later one replaces an earlier one. The held request is applied one cycle after `busy` falls.
- R8: A write to address 5 sets the source field of all four levels to data bits [1:0], but only while dynamic scaling is off. While it is on, the write has no effect.
- R9: The level in use never goes directly from 2 or 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| src_sel | output | 2 | Active clock source select |
| div_code | output | 3 | Active divider code |
| alt_sel | output | 1 | Active alternate clock select |
| cur_level | output | 2 | Load level in use |
| busy | output | 1 | Settling sequence in progress |

## Verification
The hardest case to reach is a level request that lands inside the settling window. The stimulus must first park the block at level 3, request level 0, and then issue two further requests on the next two edges. The bench then checks that level 1 holds for exactly the settle length, that level 0 appears for one cycle, and that only the later held request takes effect. A second detour with nothing held confirms that level 0 then stays put. The source broadcast is made visible through the outputs: the bench writes it while scaling is on and reads the unchanged sources back, and later writes it while scaling is off and sees the new source once scaling returns.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int LVL_W     = 2;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int NUM_WORDS = NUM_LVL / 2;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = DATA_W / 2;
  localparam int DIV_W     = 3;
  localparam int SRC_W     = 2;

  // field offsets within one 16-bit half
  localparam int DIV_OFF = 13;
  localparam int ALT_OFF = 11;
  localparam int SRC_OFF = 9;

  // static selection layout
  localparam int ST_SRC_OFF = 0;
  localparam int ST_ALT_OFF = 3;
  localparam int ST_DIV_OFF = 4;

  localparam int EN_BIT = 31;

  // register addresses
  localparam int A_MODE     = 0;
  localparam int A_LEVEL    = 1;
  localparam int A_CFG_BASE = 2;
  localparam int A_STATIC   = 4;
  localparam int A_BCAST    = 5;

  localparam logic [DIV_W-1:0] DIV_INVALID = 3'd7;
  localparam logic [LVL_W-1:0] LVL_TOP     = 2'd0;
  localparam logic [LVL_W-1:0] LVL_STEP    = 2'd1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             alt;
    logic [SRC_W-1:0] src;
  } lvl_cfg_t;

  // a move to the top level from level 2 or 3 must pass through level 1
  function automatic logic needs_detour(logic [LVL_W-1:0] cur, logic [LVL_W-1:0] req);
    return (req == LVL_TOP) && (cur > LVL_STEP);
  endfunction

  function automatic logic [DIV_W-1:0] sanitize_div(logic [DIV_W-1:0] raw);
    return (raw == DIV_INVALID) ? '0 : raw;
  endfunction
endpackage

// File: rtl/dvfs_regs.sv
module dvfs_regs
  import dvfs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic                      dyn_en,
  output logic                      lvl_req_v,
  output logic [LVL_W-1:0]          lvl_req,
  output lvl_cfg_t [NUM_LVL-1:0]    cfg,
  output lvl_cfg_t                  stat
);
  logic                   dyn_en_q;
  lvl_cfg_t [NUM_LVL-1:0] cfg_q;
  lvl_cfg_t               stat_q;
  logic                   bcast_hit;
  logic                   spare_unused;

  assign bcast_hit = wr_en && (wr_addr == ADDR_W'(A_BCAST));
  assign lvl_req_v = wr_en && (wr_addr == ADDR_W'(A_LEVEL));
  assign lvl_req   = wr_data[LVL_W-1:0];
  assign spare_unused = ^{wr_data[28], wr_data[24:16], wr_data[12], wr_data[8:7], wr_data[2]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dyn_en_q <= 1'b0;
      cfg_q    <= '0;
      stat_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_MODE)) dyn_en_q <= wr_data[EN_BIT];
      if (wr_addr == ADDR_W'(A_STATIC)) begin
        stat_q.src <= wr_data[ST_SRC_OFF +: SRC_W];
        stat_q.alt <= wr_data[ST_ALT_OFF];
        stat_q.div <= wr_data[ST_DIV_OFF +: DIV_W];
      end
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (wr_addr == ADDR_W'(A_CFG_BASE + w)) begin
          for (int hh = 0; hh < 2; hh++) begin
            // upper half (hh=1) holds the even level
            cfg_q[2*w+1-hh].div <= wr_data[hh*HALF_W+DIV_OFF +: DIV_W];
            cfg_q[2*w+1-hh].alt <= wr_data[hh*HALF_W+ALT_OFF];
            cfg_q[2*w+1-hh].src <= wr_data[hh*HALF_W+SRC_OFF +: SRC_W];
          end
        end
      end
      if (bcast_hit && !dyn_en_q) begin
        for (int i = 0; i < NUM_LVL; i++) cfg_q[i].src <= wr_data[SRC_W-1:0];
      end
    end
  end

  assign dyn_en = dyn_en_q;
  assign cfg    = cfg_q;
  assign stat   = stat_q;

  AST_SRC_LOCK: assert property (@(posedge clk) disable iff (rst)
    (bcast_hit && dyn_en_q) |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int SETTLE_CYC = 500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_v,
  input  logic [LVL_W-1:0] req,
  output logic [LVL_W-1:0] cur_level,
  output logic             busy
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

  logic [LVL_W-1:0] lvl_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_v_q;
  logic [LVL_W-1:0] pend_q;

  // named events for the assertions
  logic             go_v;
  logic [LVL_W-1:0] go_lvl;
  logic             start_detour;
  logic             settle_done;

  assign go_v         = !busy_q && (req_v || pend_v_q);
  assign go_lvl       = req_v ? req : pend_q;
  assign start_detour = go_v && needs_detour(lvl_q, go_lvl);
  assign settle_done  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lvl_q    <= '0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (busy_q) begin
      if (req_v) begin
        pend_v_q <= 1'b1;
        pend_q   <= req;
      end
      if (settle_done) begin
        busy_q <= 1'b0;
        lvl_q  <= LVL_TOP;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (go_v) begin
      pend_v_q <= 1'b0;
      if (start_detour) begin
        lvl_q  <= LVL_STEP;
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end else begin
        lvl_q <= go_lvl;
      end
    end
  end

  assign cur_level = lvl_q;
  assign busy      = busy_q;

  AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (lvl_q > LVL_STEP) |=> (lvl_q != LVL_TOP)); // R9
  AST_BUSY_AT_STEP: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (lvl_q == LVL_STEP)); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (lvl_q == LVL_TOP)); // R6
  AST_PEND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (pend_v_q && !busy_q) |=> !pend_v_q); // R7
endmodule

// File: rtl/dvfs_outsel.sv
module dvfs_outsel
  import dvfs_pkg::*;
(
  input  logic                   dyn_en,
  input  logic [LVL_W-1:0]       cur_level,
  input  lvl_cfg_t [NUM_LVL-1:0] cfg,
  input  lvl_cfg_t               stat,
  output logic [SRC_W-1:0]       src_sel,
  output logic [DIV_W-1:0]       div_code,
  output logic                   alt_sel
);
  lvl_cfg_t lvl_pick;

  always_comb begin
    lvl_pick = cfg[cur_level];
    if (dyn_en) begin
      src_sel  = lvl_pick.src;
      div_code = lvl_pick.div;
      alt_sel  = lvl_pick.alt;
    end else begin
      src_sel  = stat.src;
      div_code = sanitize_div(stat.div);
      alt_sel  = stat.alt;
    end
  end
endmodule

// File: rtl/cpu_dvfs_clkctl.sv
module cpu_dvfs_clkctl
  import dvfs_pkg::*;
#(
  parameter int SETTLE_CYC = 500_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [1:0]  src_sel,
  output logic [2:0]  div_code,
  output logic        alt_sel,
  output logic [1:0]  cur_level,
  output logic        busy
);
  logic                   dyn_en;
  logic                   lvl_req_v;
  logic [LVL_W-1:0]       lvl_req;
  lvl_cfg_t [NUM_LVL-1:0] cfg;
  lvl_cfg_t               stat;

  dvfs_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dyn_en(dyn_en), .lvl_req_v(lvl_req_v), .lvl_req(lvl_req), .cfg(cfg), .stat(stat)
  );

  dvfs_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_v(lvl_req_v), .req(lvl_req),
    .cur_level(cur_level), .busy(busy)
  );

  dvfs_outsel u_sel (
    .dyn_en(dyn_en), .cur_level(cur_level), .cfg(cfg), .stat(stat),
    .src_sel(src_sel), .div_code(div_code), .alt_sel(alt_sel)
  );

  AST_STATIC_DIV: assert property (@(posedge clk) disable iff (rst)
    !dyn_en |-> (div_code != DIV_INVALID)); // R2
  AST_BUSY_NEEDS_DYN_LVL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cur_level == LVL_STEP)); // R6
endmodule

// File: tb/cpu_dvfs_clkctl_tb_top.sv
module cpu_dvfs_clkctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int WDOG_CYC   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  src_sel;
  logic [2:0]  div_code;
  logic        alt_sel;
  logic [1:0]  cur_level;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_dvfs_clkctl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_sel(src_sel), .div_code(div_code), .alt_sel(alt_sel),
    .cur_level(cur_level), .busy(busy)
  );

  // expected item: {level, busy, src, div, alt}
  function automatic logic [8:0] mk_exp(int lvl, int bsy, int src, int dv, int alt);
    return {2'(lvl), 1'(bsy), 2'(src), 3'(dv), 1'(alt)};
  endfunction

  // one 16-bit level half: div at 15:13, alt at 11, src at 10:9
  function automatic logic [15:0] mk_half(int dv, int alt, int src);
    logic [15:0] h = '0;
    h[15:13] = 3'(dv);
    h[11]    = 1'(alt);
    h[10:9]  = 2'(src);
    return h;
  endfunction

  task automatic push_exp(string tag, logic [8:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag, logic [8:0] e);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk);
    push_exp(tag, e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(string tag, logic [8:0] e);
    @(posedge clk);
    push_exp(tag, e);
    @(negedge clk);
  endtask

  // monitor: compare every pending expectation away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [8:0] e;
        logic [8:0] got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {cur_level, busy, src_sel, div_code, alt_sel};
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s lvl/busy/src/div/alt actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                   t, got[8:7], got[6], got[5:4], got[3:1], got[0],
                   e[8:7], e[6], e[5:4], e[3:1], e[0]);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < WDOG_CYC && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset state", mk_exp(0, 0, 0, 0, 0));

    // R2 static selection
    wr(4, 32'h0000_005A, "R2 static fields", mk_exp(0, 0, 2, 5, 1));
    wr(4, 32'h0000_0071, "R2 static div 7 reads 0", mk_exp(0, 0, 1, 0, 0));

    // R4 program level words while static: outputs stay static (R3)
    wr(2, {mk_half(1, 1, 3), mk_half(2, 0, 1)}, "R3 cfg lo while off", mk_exp(0, 0, 1, 0, 0));
    wr(3, {mk_half(4, 1, 2), mk_half(6, 0, 0)}, "R3 cfg hi while off", mk_exp(0, 0, 1, 0, 0));
    wr(0, 32'h7FFF_FFFF, "R3 other mode bits no effect", mk_exp(0, 0, 1, 0, 0));
    wr(0, 32'h8000_0000, "R4 enable level 0 upper half", mk_exp(0, 0, 3, 1, 1));

    // R8 broadcast ignored while enabled
    wr(5, 32'h0000_0000, "R8 bcast ignored at L0", mk_exp(0, 0, 3, 1, 1));
    wr(1, 32'd2, "R5 R8 to level 2", mk_exp(2, 0, 2, 4, 1));
    wr(1, 32'd1, "R5 R4 to level 1", mk_exp(1, 0, 1, 2, 0));
    wr(1, 32'd3, "R5 R4 to level 3", mk_exp(3, 0, 0, 6, 0));

    // R6/R7 detour with held requests
    wr(1, 32'd0, "R6 detour start", mk_exp(1, 1, 1, 2, 0));
    wr(1, 32'd2, "R7 held req 2", mk_exp(1, 1, 1, 2, 0));
    wr(1, 32'd3, "R7 held req 3", mk_exp(1, 1, 1, 2, 0));
    for (int i = 3; i < SETTLE; i++) idle("R6 settling", mk_exp(1, 1, 1, 2, 0));
    idle("R6 reach level 0", mk_exp(0, 0, 3, 1, 1));
    idle("R7 latest held applied", mk_exp(3, 0, 0, 6, 0));

    // R5 direct 1 -> 0
    wr(1, 32'd1, "R5 3 to 1", mk_exp(1, 0, 1, 2, 0));
    wr(1, 32'd0, "R5 1 to 0 direct", mk_exp(0, 0, 3, 1, 1));

    // R8 broadcast while disabled
    wr(0, 32'h0000_0000, "R3 disable", mk_exp(0, 0, 1, 0, 0));
    wr(5, 32'h0000_0002, "R8 bcast static unchanged", mk_exp(0, 0, 1, 0, 0));
    wr(0, 32'h8000_0000, "R8 L0 new source", mk_exp(0, 0, 2, 1, 1));
    wr(1, 32'd3, "R8 L3 new source", mk_exp(3, 0, 2, 6, 0));
    wr(1, 32'd2, "R8 L2 new source", mk_exp(2, 0, 2, 4, 1));

    // R6 detour from 2 with nothing held
    wr(1, 32'd0, "R6 detour from 2", mk_exp(1, 1, 2, 2, 0));
    for (int i = 1; i < SETTLE; i++) idle("R6 settling from 2", mk_exp(1, 1, 2, 2, 0));
    idle("R6 level 0 after settle", mk_exp(0, 0, 2, 1, 1));
    idle("R7 nothing held stays 0", mk_exp(0, 0, 2, 1, 1));

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule